// File: doc/BRIEF.md
# Serial Flash Write-Protect Controller

This block keeps the protection state of a small serial flash memory and rules on every write that reaches it. It holds a write-enable latch, a two-bit block lockout level and a write-protect-enable bit. It also watches an active-low write-protect pin. Decoded command pulses reach it from the serial front end. For each array program request it answers, one cycle later, with exactly one of a grant pulse or a deny pulse. For each status-register write it either refuses at once or runs a self-timed update with a busy phase.

The lockout level covers none, the top quarter, the top half or all of the address space. The pin and the enable bit together form hardware protection, which freezes the status register. The array stays writable outside the lockout range. When the write-enable latch is clear, every write is refused. The status byte is presented continuously, so a status read is always served, even while the block is busy.

Top module: `sfwp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, and busy and all four response pulses are low.
- R2: A write-enable pulse sets the latch (status bit 1), and the new value is visible in the next cycle. A write-disable pulse clears the latch when the block is not busy.
- R3: A program request sampled at a clock edge yields, in the following cycle, exactly one of prog_ok_o or prog_deny_o. The grant is given only when the latch is 1 and the address is outside the lockout range. When the latch is 0 the request is always denied.
- R4: The lockout level is held in status bits 3:2. Code 00 locks nothing. Code 01 locks addresses whose two top bits are 11. Code 10 locks addresses whose top bit is 1. Code 11 locks every address.
- R5: Hardware protection is active when the resynchronised pin is low and the enable bit (status bit 7) is 1. While it is active, a status write is refused, but a program request to an address outside the lockout range with the latch set is still granted.
- R6: A status write is accepted when the block is not busy, the latch is 1 and hardware protection is inactive. Acceptance gives a wrsr_ok_o pulse. Busy (status bit 0 and busy_o) is then high for exactly BUSY_CYCLES cycles. In the cycle busy falls, data bits 7 and 3:2 are loaded into the status byte and the latch clears.
- R7: A refused status write gives a wrsr_deny_o pulse, clears the latch, starts no busy phase and leaves bits 7 and 3:2 unchanged.
- R8: While busy, write-enable, write-disable, status-write and program requests have no effect and produce no response pulse.
- R9: While the pin stays low, the enable bit cannot be cleared. Once the pin is high again, a status write can clear it.
- R10: Status bits 6:4 always read 0. Data bits 6:4 and 1:0 of a status write are ignored.
- R11: Commands arriving together are resolved in a fixed order: a status write is served first, then write-disable, then write-enable. The losing commands in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_n_i | input | 1 | Write-protect pin, active low, asynchronous |
| cmd_wren_i | input | 1 | Write-enable command pulse |
| cmd_wrdi_i | input | 1 | Write-disable command pulse |
| cmd_wrsr_i | input | 1 | Status-register write command pulse |
| wrsr_data_i | input | 8 | Data byte for the status write |
| prog_req_i | input | 1 | Array program request pulse |
| prog_addr_i | input | ADDR_W | Target byte address of the program request |
| status_o | output | 8 | Status byte: bit 7 enable, bits 3:2 level, bit 1 latch, bit 0 busy |
| busy_o | output | 1 | Self-timed status write in progress |
| prog_ok_o | output | 1 | Program request granted |
| prog_deny_o | output | 1 | Program request denied |
| wrsr_ok_o | output | 1 | Status write accepted, busy phase started |
| wrsr_deny_o | output | 1 | Status write refused |

## Verification
Every response pulse and every change to the latch becomes visible one cycle after the edge that sampled the command. Stimulus is applied on the falling edge and held for one full cycle. Outputs are read at the next falling edge, exactly one register stage later. The busy phase is measured by counting falling edges while busy_o is high, starting with the cycle that shows the accept pulse, and the total is compared with BUSY_CYCLES. The status byte is read again right after busy falls, to confirm the new bits and the cleared latch. The write-protect pin passes through a resynchroniser, so after every pin change the bench waits four cycles before it issues the next command.

// File: rtl/sfwp_pkg.sv
package sfwp_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_lvl_e;

  localparam int unsigned ST_W     = 8;
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_WEL   = 1;
  localparam int unsigned ST_LVL_L = 2;
  localparam int unsigned ST_LVL_H = 3;
  localparam int unsigned ST_WPEN  = 7;

endpackage

// File: rtl/sfwp_sync.sv
module sfwp_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic din;
      if (s == 0) begin : g_first
        assign din = d_i;
      end else begin : g_next
        assign din = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RESET_VAL;
        else        chain_q[s] <= din;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sfwp_lock_map.sv
module sfwp_lock_map
  import sfwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  lock_lvl_e         lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);

  localparam int unsigned TOP = ADDR_W - 1;

  logic in_top_half;
  logic in_top_quarter;

  assign in_top_half    = addr_i[TOP];
  assign in_top_quarter = addr_i[TOP] & addr_i[TOP-1];

  always_comb begin
    unique case (lvl_i)
      LOCK_NONE:    locked_o = 1'b0;
      LOCK_QUARTER: locked_o = in_top_quarter;
      LOCK_HALF:    locked_o = in_top_half;
      LOCK_ALL:     locked_o = 1'b1;
      default:      locked_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/sfwp_busy_seq.sv
module sfwp_busy_seq #(
  parameter int unsigned BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign done_o = busy_q && (cnt_q == '0);
  assign cnt_en = start_i || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_i && !busy_q) begin
      cnt_d  = CNT_LOAD;
      busy_d = 1'b1;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/sfwp_ctrl.sv
module sfwp_ctrl
  import sfwp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned BUSY_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              cmd_wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              prog_req_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              prog_ok_o,
  output logic              prog_deny_o,
  output logic              wrsr_ok_o,
  output logic              wrsr_deny_o
);

  // Internal reset: asserted asynchronously, released on a clock edge
  logic rst_n_s;
  sfwp_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_n_s)
  );

  // Pin resynchroniser, resets to the protecting level
  logic wp_n_s;
  sfwp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (wp_n_i),
    .q_o   (wp_n_s)
  );

  // State
  logic      wel_q, wel_d;
  logic      wpen_q, wpen_d;
  lock_lvl_e lvl_q, lvl_d;
  logic      pend_wpen_q, pend_wpen_d;
  lock_lvl_e pend_lvl_q, pend_lvl_d;
  logic      pok_q, pok_d, pdn_q, pdn_d, sok_q, sok_d, sdn_q, sdn_d;

  logic busy, done;
  logic hw_prot;
  logic locked;
  logic sr_accept, sr_refuse;
  logic pend_en, st_en;
  logic unused_data;

  assign unused_data = ^{wrsr_data_i[6:4], wrsr_data_i[1:0]};

  sfwp_lock_map #(.ADDR_W(ADDR_W)) u_lock_map (
    .lvl_i    (lvl_q),
    .addr_i   (prog_addr_i),
    .locked_o (locked)
  );

  sfwp_busy_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (sr_accept),
    .busy_o  (busy),
    .done_o  (done)
  );

  assign hw_prot   = !wp_n_s && wpen_q;
  assign sr_accept = cmd_wrsr_i && !busy && wel_q && !hw_prot;
  assign sr_refuse = cmd_wrsr_i && !busy && !sr_accept;

  // Write-enable latch next state, status write has priority
  always_comb begin
    wel_d = wel_q;
    if (done) begin
      wel_d = 1'b0;
    end else if (!busy) begin
      if (cmd_wrsr_i)      wel_d = sr_accept;
      else if (cmd_wrdi_i) wel_d = 1'b0;
      else if (cmd_wren_i) wel_d = 1'b1;
    end
  end

  // Pending status bits captured on accept, committed on completion
  assign pend_en     = sr_accept;
  assign pend_wpen_d = wrsr_data_i[ST_WPEN];
  assign pend_lvl_d  = lock_lvl_e'(wrsr_data_i[ST_LVL_H:ST_LVL_L]);

  assign st_en  = done;
  assign wpen_d = pend_wpen_q;
  assign lvl_d  = pend_lvl_q;

  // Response pulses
  always_comb begin
    pok_d = prog_req_i && !busy && wel_q && !locked;
    pdn_d = prog_req_i && !busy && !(wel_q && !locked);
    sok_d = sr_accept;
    sdn_d = sr_refuse;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wel_q <= 1'b0;
    end else begin
      wel_q <= wel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pend_wpen_q <= 1'b0;
      pend_lvl_q  <= LOCK_NONE;
    end else if (pend_en) begin
      pend_wpen_q <= pend_wpen_d;
      pend_lvl_q  <= pend_lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wpen_q <= 1'b0;
      lvl_q  <= LOCK_NONE;
    end else if (st_en) begin
      wpen_q <= wpen_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pok_q <= 1'b0;
      pdn_q <= 1'b0;
      sok_q <= 1'b0;
      sdn_q <= 1'b0;
    end else begin
      pok_q <= pok_d;
      pdn_q <= pdn_d;
      sok_q <= sok_d;
      sdn_q <= sdn_d;
    end
  end

  always_comb begin
    status_o                    = '0;
    status_o[ST_WPEN]           = wpen_q;
    status_o[ST_LVL_H:ST_LVL_L] = lvl_q;
    status_o[ST_WEL]            = wel_q;
    status_o[ST_BUSY]           = busy;
  end

  assign busy_o      = busy;
  assign prog_ok_o   = pok_q;
  assign prog_deny_o = pdn_q;
  assign wrsr_ok_o   = sok_q;
  assign wrsr_deny_o = sdn_q;

endmodule

// File: rtl/sfwp_ctrl_chk.sv
module sfwp_ctrl_chk #(
  parameter int unsigned BUSY_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_req_i,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       prog_ok_o,
  input logic       prog_deny_o,
  input logic       wrsr_ok_o,
  input logic       wrsr_deny_o
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  a_r3_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_ok_o && prog_deny_o));

  a_r3_answer_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ok_o || prog_deny_o) |-> $past(prog_req_i));

  a_r3_grant_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok_o |-> $past(status_o[1]));

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_ok_o |-> busy_o);

  a_r6_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !status_o[1]);

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == BUSY_CYCLES));

  a_r7_refuse_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_deny_o |-> (!busy_o && !status_o[1]));

  a_r8_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_o) |-> !(prog_ok_o || prog_deny_o || wrsr_ok_o || wrsr_deny_o));

  a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);

endmodule

bind sfwp_ctrl sfwp_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_req_i  (prog_req_i),
  .status_o    (status_o),
  .busy_o      (busy_o),
  .prog_ok_o   (prog_ok_o),
  .prog_deny_o (prog_deny_o),
  .wrsr_ok_o   (wrsr_ok_o),
  .wrsr_deny_o (wrsr_deny_o)
);

// File: tb/sfwp_ctrl_bench.sv
module sfwp_ctrl_bench;

  localparam int unsigned AW = 17;
  localparam int unsigned BC = 16;

  logic          clk;
  logic          rst_n;
  logic          wp_n;
  logic          wren, wrdi, wrsr, preq;
  logic [7:0]    sdata;
  logic [AW-1:0] paddr;
  logic [7:0]    status;
  logic          busy, pok, pdn, sok, sdn;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  sfwp_ctrl #(.ADDR_W(AW), .BUSY_CYCLES(BC), .SYNC_STAGES(2)) u_sfwp_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n),
    .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr),
    .wrsr_data_i(sdata), .prog_req_i(preq), .prog_addr_i(paddr),
    .status_o(status), .busy_o(busy), .prog_ok_o(pok), .prog_deny_o(pdn),
    .wrsr_ok_o(sok), .wrsr_deny_o(sdn)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Table entry: {level[1:0], set_latch, addr[16:0], expect_grant}
  localparam logic [20:0] VEC [12] = '{
    {2'b00, 1'b1, 17'h00000, 1'b1},
    {2'b00, 1'b1, 17'h1FFFF, 1'b1},
    {2'b00, 1'b0, 17'h00000, 1'b0},
    {2'b01, 1'b1, 17'h17FFF, 1'b1},
    {2'b01, 1'b1, 17'h18000, 1'b0},
    {2'b01, 1'b1, 17'h1FFFF, 1'b0},
    {2'b10, 1'b1, 17'h0FFFF, 1'b1},
    {2'b10, 1'b1, 17'h10000, 1'b0},
    {2'b11, 1'b1, 17'h00000, 1'b0},
    {2'b11, 1'b1, 17'h0FFFF, 1'b0},
    {2'b01, 1'b0, 17'h00000, 1'b0},
    {2'b10, 1'b1, 17'h00001, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cmd(input logic en, input logic dis, input logic sr,
                     input logic [7:0] d, input logic pr, input logic [AW-1:0] a);
    @(negedge clk);
    wren = en; wrdi = dis; wrsr = sr; sdata = d; preq = pr; paddr = a;
    @(negedge clk);
    wren = 0; wrdi = 0; wrsr = 0; sdata = '0; preq = 0; paddr = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_status(input logic wpen, input logic [1:0] lvl);
    cmd(1, 0, 0, 8'h00, 0, '0);
    cmd(0, 0, 1, {wpen, 3'b000, lvl, 2'b00}, 0, '0);
    check("R6 setup accept", int'(sok), 1);
    wait_idle();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; wp_n = 1; wren = 0; wrdi = 0; wrsr = 0; preq = 0;
    sdata = '0; paddr = '0;
    idle(3);
    rst_n = 1;
    idle(6);

    // R1: reset state
    check("R1 status", int'(status), 8'h00);
    check("R1 pulses", int'({busy, pok, pdn, sok, sdn}), 0);

    // R2: latch set and clear
    cmd(1, 0, 0, 8'h00, 0, '0);
    check("R2 set", int'(status), 8'h02);
    cmd(0, 1, 0, 8'h00, 0, '0);
    check("R2 clear", int'(status), 8'h00);

    // R11: disable beats enable
    cmd(1, 1, 0, 8'h00, 0, '0);
    check("R11 wren+wrdi", int'(status), 8'h00);
    // R11: status write served, enable dropped
    cmd(1, 0, 1, 8'h0C, 0, '0);
    check("R11 wrsr+wren deny", int'(sdn), 1);
    check("R11 wrsr+wren status", int'(status), 8'h00);

    // R3/R4: table walk
    foreach (VEC[i]) begin
      logic [20:0] v;
      v = VEC[i];
      set_status(1'b0, v[20:19]);
      if (v[18]) cmd(1, 0, 0, 8'h00, 0, '0);
      cmd(0, 0, 0, 8'h00, 1, v[17:1]);
      check("R4 grant", int'(pok), int'(v[0]));
      check("R3 deny", int'(pdn), int'(!v[0]));
    end
    set_status(1'b0, 2'b00);

    // R7: refused write without latch
    cmd(0, 0, 1, 8'h8C, 0, '0);
    check("R7 deny", int'(sdn), 1);
    check("R7 no busy", int'(busy), 0);
    check("R7 status", int'(status), 8'h00);

    // R6/R10: busy length and commit, ignored data bits
    cmd(1, 0, 0, 8'h00, 0, '0);
    cmd(0, 0, 1, 8'hFF, 0, '0);
    check("R6 accept", int'(sok), 1);
    check("R6 status during busy", int'(status), 8'h03);
    begin
      int n;
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check("R6 busy length", n, BC);
    end
    check("R10 status after commit", int'(status), 8'h8C);
    set_status(1'b0, 2'b00);

    // R11: status write beats disable, R8: ignored while busy
    cmd(1, 0, 0, 8'h00, 0, '0);
    cmd(0, 1, 1, 8'h08, 0, '0);
    check("R11 wrsr+wrdi accept", int'(sok), 1);
    cmd(0, 1, 0, 8'h00, 0, '0);
    check("R8 wrdi ignored", int'(status), 8'h03);
    cmd(0, 0, 0, 8'h00, 1, '0);
    check("R8 prog ignored", int'({pok, pdn}), 0);
    cmd(0, 0, 1, 8'h8C, 0, '0);
    check("R8 wrsr ignored", int'({sok, sdn}), 0);
    wait_idle();
    check("R8 final status", int'(status), 8'h08);

    // R5/R9: hardware protection
    set_status(1'b1, 2'b01);
    check("R9 enable set", int'(status), 8'h84);
    wp_n = 0;
    idle(4);
    cmd(1, 0, 0, 8'h00, 0, '0);
    check("R5 latch", int'(status), 8'h86);
    cmd(0, 0, 0, 8'h00, 1, 17'h00000);
    check("R5 open grant", int'(pok), 1);
    cmd(0, 0, 0, 8'h00, 1, 17'h18000);
    check("R5 locked deny", int'(pdn), 1);
    cmd(0, 0, 1, 8'h00, 0, '0);
    check("R5 wrsr deny", int'(sdn), 1);
    check("R9 enable held", int'(status), 8'h84);
    wp_n = 1;
    idle(4);
    set_status(1'b0, 2'b00);
    check("R9 enable cleared", int'(status), 8'h00);

    summary();
  end

endmodule